// File: doc/BRIEF.md
# Multi-Model State-Space Step Solver

This block advances a linear discrete-time plant model by one time step. For the selected model it forms x[k+1] = x[k] + round(A·x[k] + B·u[k]) in signed fixed point. The step size is already folded into the A and B coefficients. The block stores complete coefficient sets for several independent models, and each model keeps its own state vector. One shared multiply-accumulate datapath serves all of them: a request names the model to advance, and only that model's state moves.

The coefficients sit in one memory per matrix row. Each cycle the solver reads one column of the combined [A | B] matrix for every row at once. It multiplies that column by a single state or input element and adds the product into one accumulator per row. A host rewrites coefficients at run time, one column per write transfer, and the write address names the model slot. Writes are not accepted while a step is running, so a step never sees a mix of old and new coefficients.

Both request channels use valid/ready handshakes.
- A step request or a column write transfers in a cycle where its valid and ready are both high.
- The requester must hold valid and its payload stable until that cycle.
- Both readies are high exactly when no step is in progress, so the solver applies back-pressure by dropping both readies for the whole step.
- The result side has no back-pressure. It is a one-cycle done pulse, and the result fields are valid in that cycle.

Top module: `ssx_step_solver`

## Requirements
- R1: After an accepted step request for model m, the solver presents on `res_state` the new state x' = x + delta for model m, with `res_model` = m, in the single cycle where `done` is high. Here delta = round(A·x + B·u).
  - Coefficients are signed CW-bit values with FRAC fractional bits.
  - State lane r sits in `res_state` bits [r*SW +: SW].
  - Input lane j sits in `step_u` bits [j*SW +: SW].
- R2: Each row's accumulated sum s (carrying FRAC fractional bits) becomes delta = floor((s + 2^(FRAC-1)) / 2^FRAC). Ties therefore round toward plus infinity.
- R3: A new state outside the signed SW-bit range saturates to 2^(SW-1)-1 or to -2^(SW-1).
- R4: A step changes only the stored state of the selected model. Every other model's state is left unchanged.
- R5: An accepted column write sets column `cw_col` of model slot `cw_model`.
  - Columns 0..NSTATE-1 are the columns of A, and column NSTATE+j is column j of B.
  - Lane r of `cw_data` (bits [r*CW +: CW]) is the coefficient for row r.
- R6: From the cycle after a step is accepted until `done`, `step_ready` and `cw_ready` are both low. A write offered during a step is therefore taken only afterwards, and it affects only later steps.
- R7: A column write and a step request accepted in the same cycle act in that order: the write is visible to that step.
- R8: `done` rises exactly NSTATE+NIN+2 clock edges after the accepting edge, and it stays high for one cycle only.
- R9: Synchronous reset clears every model's state to zero and keeps all coefficients. After reset, `done` is low and both readies are high.
- R10: A column write with `cw_col` >= NSTATE+NIN is ignored. It changes no coefficient of any model slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_valid | input | 1 | Step request valid |
| step_ready | output | 1 | Solver idle, can take a step |
| step_model | input | MW | Model to advance |
| step_u | input | NIN*SW | Input vector u, lane j at j*SW |
| cw_valid | input | 1 | Column write valid |
| cw_ready | output | 1 | Column write can be taken |
| cw_model | input | MW | Model slot written |
| cw_col | input | CLW | Column index (A then B) |
| cw_data | input | NSTATE*CW | One coefficient per row |
| done | output | 1 | One-cycle step completion pulse |
| res_model | output | MW | Model that was advanced |
| res_state | output | NSTATE*SW | New state vector, lane r at r*SW |

## Verification
The bench builds the solver with three states, two inputs and four model slots. With these values a column index is three bits wide and only five of its eight codes are legal. The illegal codes 5 to 7 can therefore be driven, and a write there would alias onto the next model's first column if it were not dropped. The small dimensions keep hand-picked coefficients readable for the rounding ties at plus and minus one half, and four slots are enough to interleave steps across models and watch the unselected state stay put. The 24-bit state width can be driven into both saturation rails within two steps, using full-scale inputs and a gain of two.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RUN   = 2'd1,
    PH_DRAIN = 2'd2,
    PH_WB    = 2'd3
  } ssx_phase_e;
endpackage

// File: rtl/ssx_coef_bank.sv
// One coefficient memory per matrix row; all rows read in parallel.
module ssx_coef_bank #(
  parameter int NROW  = 9,
  parameter int CW    = 18,
  parameter int DEPTH = 52,
  parameter int AW    = 6
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic [NROW*CW-1:0]   wdata,
  input  logic [AW-1:0]        raddr,
  output logic [NROW*CW-1:0]   rdata
);
  for (genvar r = 0; r < NROW; r++) begin : g_row
    logic [CW-1:0] mem [DEPTH];
    logic [CW-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata[r*CW +: CW];
    end

    always_ff @(posedge clk) begin
      rd_q <= mem[raddr];
    end

    assign rdata[r*CW +: CW] = rd_q;
  end
endmodule

// File: rtl/ssx_mac_lanes.sv
// One accumulator per row; the same operand is broadcast to every lane.
module ssx_mac_lanes #(
  parameter int NROW = 9,
  parameter int CW   = 18,
  parameter int OW   = 24,
  parameter int ACCW = 47
) (
  input  logic                  clk,
  input  logic                  clr,
  input  logic                  en,
  input  logic [NROW*CW-1:0]    coef,
  input  logic signed [OW-1:0]  op,
  output logic [NROW*ACCW-1:0]  acc
);
  localparam int PW = CW + OW;

  for (genvar r = 0; r < NROW; r++) begin : g_lane
    logic signed [PW-1:0]   prod;
    logic signed [ACCW-1:0] acc_q;

    assign prod = $signed(coef[r*CW +: CW]) * op;

    always_ff @(posedge clk) begin
      if (clr)     acc_q <= '0;
      else if (en) acc_q <= acc_q + ACCW'(prod);
    end

    assign acc[r*ACCW +: ACCW] = acc_q;
  end
endmodule

// File: rtl/ssx_update_sat.sv
// Round each accumulator to the state grid, add the old state, saturate.
module ssx_update_sat #(
  parameter int NROW = 9,
  parameter int SW   = 24,
  parameter int ACCW = 47,
  parameter int FRAC = 15
) (
  input  logic [NROW*ACCW-1:0] acc,
  input  logic [NROW*SW-1:0]   xin,
  output logic [NROW*SW-1:0]   xout
);
  localparam int WW = ACCW + 2;

  for (genvar r = 0; r < NROW; r++) begin : g_upd
    logic signed [WW-1:0] a_w;
    logic signed [WW-1:0] half;
    logic signed [WW-1:0] delta;
    logic signed [WW-1:0] sum;
    logic [WW-SW:0]       hi;
    logic [SW-1:0]        y;

    assign a_w   = WW'($signed(acc[r*ACCW +: ACCW]));
    assign half  = WW'(1) <<< (FRAC - 1);
    assign delta = (a_w + half) >>> FRAC;
    assign sum   = WW'($signed(xin[r*SW +: SW])) + delta;
    assign hi    = sum[WW-1:SW-1];

    always_comb begin
      if (hi == '0 || hi == '1) y = sum[SW-1:0];
      else if (!sum[WW-1])      y = {1'b0, {(SW-1){1'b1}}};
      else                      y = {1'b1, {(SW-1){1'b0}}};
    end

    assign xout[r*SW +: SW] = y;
  end
endmodule

// File: rtl/ssx_step_solver.sv
module ssx_step_solver #(
  parameter int NSTATE = 9,
  parameter int NIN    = 4,
  parameter int NMODEL = 4,
  parameter int CW     = 18,
  parameter int FRAC   = 15,
  parameter int SW     = 24,
  localparam int NCOL  = NSTATE + NIN,
  localparam int CLW   = $clog2(NCOL),
  localparam int MW    = (NMODEL > 1) ? $clog2(NMODEL) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  step_valid,
  output logic                  step_ready,
  input  logic [MW-1:0]         step_model,
  input  logic [NIN*SW-1:0]     step_u,
  input  logic                  cw_valid,
  output logic                  cw_ready,
  input  logic [MW-1:0]         cw_model,
  input  logic [CLW-1:0]        cw_col,
  input  logic [NSTATE*CW-1:0]  cw_data,
  output logic                  done,
  output logic [MW-1:0]         res_model,
  output logic [NSTATE*SW-1:0]  res_state
);
  import ssx_pkg::*;

  localparam int DEPTH = NMODEL * NCOL;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int ACCW  = CW + SW + CLW + 1;

  ssx_phase_e phase;
  logic [CLW-1:0] col_q;
  logic [MW-1:0]  cur_model;
  logic           mac_en;
  logic           done_q;
  logic           step_fire;
  logic           cw_fire;
  logic           we;
  logic [AW-1:0]  waddr;
  logic [AW-1:0]  raddr;

  logic signed [SW-1:0] st_q   [NMODEL][NSTATE];
  logic signed [SW-1:0] x_snap [NSTATE];
  logic signed [SW-1:0] u_snap [NIN];
  logic signed [SW-1:0] op_next;
  logic signed [SW-1:0] op_q;
  logic [NSTATE*SW-1:0]   x_flat;
  logic [NSTATE*SW-1:0]   x_new;
  logic [NSTATE*SW-1:0]   res_q;
  logic [MW-1:0]          res_model_q;
  logic [NSTATE*CW-1:0]   rd_coef;
  logic [NSTATE*ACCW-1:0] acc;

  assign step_ready = (phase == PH_IDLE);
  assign cw_ready   = (phase == PH_IDLE);
  assign step_fire  = step_valid && step_ready;
  assign cw_fire    = cw_valid && cw_ready;
  assign we         = cw_fire && (int'(cw_col) < NCOL);
  assign waddr      = AW'(cw_model) * AW'(NCOL) + AW'(cw_col);
  assign raddr      = AW'(cur_model) * AW'(NCOL) + AW'(col_q);

  // Step sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      col_q     <= '0;
      cur_model <= '0;
      mac_en    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      mac_en <= (phase == PH_RUN);
      case (phase)
        PH_IDLE: if (step_fire) begin
          phase     <= PH_RUN;
          col_q     <= '0;
          cur_model <= step_model;
        end
        PH_RUN: begin
          if (col_q == CLW'(NCOL - 1)) phase <= PH_DRAIN;
          else                         col_q <= col_q + 1'b1;
        end
        PH_DRAIN: phase <= PH_WB;
        PH_WB: begin
          phase  <= PH_IDLE;
          done_q <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // Operand for the column being issued: state element, then input element
  always_comb begin
    op_next = '0;
    for (int k = 0; k < NSTATE; k++)
      if (int'(col_q) == k) op_next = x_snap[k];
    for (int j = 0; j < NIN; j++)
      if (int'(col_q) == NSTATE + j) op_next = u_snap[j];
  end

  // Snapshot of the selected state and the inputs at acceptance
  always_ff @(posedge clk) begin
    if (step_fire) begin
      for (int k = 0; k < NSTATE; k++) x_snap[k] <= st_q[step_model][k];
      for (int j = 0; j < NIN; j++)    u_snap[j] <= $signed(step_u[j*SW +: SW]);
    end
    op_q <= op_next;
  end

  for (genvar r = 0; r < NSTATE; r++) begin : g_xflat
    assign x_flat[r*SW +: SW] = x_snap[r];
  end

  // Per-model state storage, cleared by reset
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int m = 0; m < NMODEL; m++)
        for (int k = 0; k < NSTATE; k++)
          st_q[m][k] <= '0;
    end else if (phase == PH_WB) begin
      for (int k = 0; k < NSTATE; k++)
        st_q[cur_model][k] <= $signed(x_new[k*SW +: SW]);
    end
  end

  always_ff @(posedge clk) begin
    if (phase == PH_WB) begin
      res_q       <= x_new;
      res_model_q <= cur_model;
    end
  end

  ssx_coef_bank #(
    .NROW(NSTATE), .CW(CW), .DEPTH(DEPTH), .AW(AW)
  ) u_bank (
    .clk(clk), .we(we), .waddr(waddr), .wdata(cw_data),
    .raddr(raddr), .rdata(rd_coef)
  );

  ssx_mac_lanes #(
    .NROW(NSTATE), .CW(CW), .OW(SW), .ACCW(ACCW)
  ) u_mac (
    .clk(clk), .clr(step_fire), .en(mac_en),
    .coef(rd_coef), .op(op_q), .acc(acc)
  );

  ssx_update_sat #(
    .NROW(NSTATE), .SW(SW), .ACCW(ACCW), .FRAC(FRAC)
  ) u_upd (
    .acc(acc), .xin(x_flat), .xout(x_new)
  );

  assign done      = done_q;
  assign res_model = res_model_q;
  assign res_state = res_q;
endmodule

// File: rtl/ssx_step_solver_chk.sv
module ssx_step_solver_chk #(
  parameter int MW  = 2,
  parameter int LAT = 15
) (
  input logic          clk,
  input logic          rst,
  input logic          step_valid,
  input logic          step_ready,
  input logic [MW-1:0] step_model,
  input logic          cw_ready,
  input logic          done,
  input logic [MW-1:0] res_model
);
  logic          pend;
  int            cnt;
  logic [MW-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= 1'b0;
      cnt   <= 0;
      tag_q <= '0;
    end else if (step_valid && step_ready) begin
      pend  <= 1'b1;
      cnt   <= 0;
      tag_q <= step_model;
    end else if (pend) begin
      cnt <= cnt + 1;
      if (done) pend <= 1'b0;
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (pend && cnt == LAT));

  assert_holdoff_R6: assert property (@(posedge clk) disable iff (rst)
    (step_valid && step_ready) |=> (!cw_ready && !step_ready));

  assert_model_tag_R1: assert property (@(posedge clk) disable iff (rst)
    done |-> (res_model == tag_q));
endmodule

bind ssx_step_solver ssx_step_solver_chk #(
  .MW(MW), .LAT(NSTATE + NIN + 2)
) u_chk (
  .clk(clk), .rst(rst), .step_valid(step_valid), .step_ready(step_ready),
  .step_model(step_model), .cw_ready(cw_ready), .done(done),
  .res_model(res_model)
);

// File: tb/ssx_step_solver_test.sv
module ssx_step_solver_test;
  localparam int NS = 3, NI = 2, NM = 4, CW = 18, SW = 24, FRAC = 15;
  localparam int NC = NS + NI, CLW = $clog2(NC), MW = $clog2(NM);
  localparam longint SMAX = (64'sd1 <<< (SW - 1)) - 1;
  localparam longint SMIN = -(64'sd1 <<< (SW - 1));

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic step_valid = 1'b0, cw_valid = 1'b0;
  logic step_ready, cw_ready, done;
  logic [MW-1:0] step_model = '0, cw_model = '0, res_model;
  logic [CLW-1:0] cw_col = '0;
  logic [NI*SW-1:0] step_u = '0;
  logic [NS*CW-1:0] cw_data = '0;
  logic [NS*SW-1:0] res_state;

  ssx_step_solver #(.NSTATE(NS), .NIN(NI), .NMODEL(NM), .CW(CW), .FRAC(FRAC), .SW(SW)) uut (
    .clk(clk), .rst(rst), .step_valid(step_valid), .step_ready(step_ready),
    .step_model(step_model), .step_u(step_u), .cw_valid(cw_valid), .cw_ready(cw_ready),
    .cw_model(cw_model), .cw_col(cw_col), .cw_data(cw_data), .done(done),
    .res_model(res_model), .res_state(res_state)
  );

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;
  longint coef [NM][NS][NC];
  longint st   [NM][NS];
  int     q_model[$];
  int     q_cyc[$];
  longint q_val[$];
  string  q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: one column write
  task automatic write_col(input int m, input int c, input int a0, input int a1, input int a2);
    @(negedge clk);
    cw_valid = 1'b1;
    cw_model = MW'(m);
    cw_col   = CLW'(c);
    cw_data  = {CW'(a2), CW'(a1), CW'(a0)};
    if (c < NC) begin
      coef[m][0][c] = a0; coef[m][1][c] = a1; coef[m][2][c] = a2;
    end
    while (!cw_ready) @(negedge clk);
    @(negedge clk);
    cw_valid = 1'b0;
  endtask

  // Driver: one step; expected values pushed at acceptance
  task automatic step(input int m, input int u0, input int u1, input string tag);
    longint acc, nv[NS], u[NI];
    @(negedge clk);
    step_valid = 1'b1;
    step_model = MW'(m);
    step_u     = {SW'(u1), SW'(u0)};
    u[0] = u0; u[1] = u1;
    while (!step_ready) @(negedge clk);
    @(posedge clk);
    #1;
    for (int r = 0; r < NS; r++) begin
      acc = 0;
      for (int c = 0; c < NS; c++) acc += coef[m][r][c] * st[m][c];
      for (int j = 0; j < NI; j++) acc += coef[m][r][NS + j] * u[j];
      nv[r] = st[m][r] + ((acc + (64'sd1 <<< (FRAC - 1))) >>> FRAC);
      if (nv[r] > SMAX) nv[r] = SMAX;
      if (nv[r] < SMIN) nv[r] = SMIN;
    end
    for (int r = 0; r < NS; r++) begin
      st[m][r] = nv[r];
      q_val.push_back(nv[r]);
    end
    q_model.push_back(m);
    q_cyc.push_back(cyc);
    q_tag.push_back(tag);
    @(negedge clk);
    step_valid = 1'b0;
  endtask

  task automatic drain();
    while (q_model.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor / scoreboard
  bit prev_done = 0;
  always @(negedge clk) begin
    if (done && prev_done) chk(0, "R8 done longer than one cycle", 1, 0);
    if (done) begin
      if (q_model.size() == 0) chk(0, "R1 unexpected done", 1, 0);
      else begin
        int m, c0;
        string tag;
        m = q_model.pop_front();
        c0 = q_cyc.pop_front();
        tag = q_tag.pop_front();
        chk(res_model == MW'(m), {tag, " R1 model"}, res_model, m);
        chk(cyc - c0 == NC + 2, "R8 latency", cyc - c0, NC + 2);
        for (int r = 0; r < NS; r++) begin
          longint e, a;
          e = q_val.pop_front();
          a = longint'($signed(res_state[r*SW +: SW]));
          chk(a == e, {tag, " state lane"}, a, e);
        end
      end
    end
    prev_done = done;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < NM; m++)
      for (int r = 0; r < NS; r++) begin
        st[m][r] = 0;
        for (int c = 0; c < NC; c++) coef[m][r][c] = 0;
      end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R9 done after reset", done, 0);
    chk(step_ready == 1'b1, "R9 step_ready after reset", step_ready, 1);
    chk(cw_ready == 1'b1, "R9 cw_ready after reset", cw_ready, 1);

    // Clear every coefficient of every slot
    for (int m = 0; m < NM; m++)
      for (int c = 0; c < NC; c++) write_col(m, c, 0, 0, 0);

    // R5 / R1: model 0 with mixed A and B
    write_col(0, 0, 16384, 0, 4096);
    write_col(0, 1, 0, -8192, 0);
    write_col(0, 2, 0, 3000, 32768);
    write_col(0, 3, 32768, 16384, -32768);
    write_col(0, 4, 0, 65536, 100);
    step(0, 1000, -2000, "R1 m0 s1");
    step(0, 1000, -2000, "R1 m0 s2");
    step(0, -500, 7000, "R1 m0 s3");
    drain();

    // R4: model 1, then model 0 state continues from its own value
    write_col(1, 0, -16384, 0, 0);
    write_col(1, 3, 32767, -32768, 12345);
    step(1, 40000, 0, "R4 m1");
    step(0, 0, 0, "R4 m0 untouched");
    step(1, -40000, 3, "R4 m1 again");
    drain();

    // R2: rounding ties at +/- one half
    write_col(2, 3, 16384, -16384, 16383);
    step(2, 1, 0, "R2 tie +0.5");
    step(2, 3, 0, "R2 tie 1.5");
    drain();

    // R3: saturation to both rails
    write_col(3, 0, 65536, 0, 0);
    write_col(3, 1, 0, 65536, 0);
    write_col(3, 3, 32767, -32768, 0);
    step(3, 8388607, 0, "R3 ramp");
    step(3, 8388607, 0, "R3 saturate");
    drain();

    // R6: write offered during a step is held off and only affects later steps
    fork
      step(0, 111, 222, "R6 old coef");
      begin
        repeat (2) @(negedge clk);
        chk(!cw_ready && !step_ready, "R6 readies low while busy", {cw_ready, step_ready}, 0);
        write_col(0, 3, -32768, 0, 16384);
      end
    join
    step(0, 111, 222, "R6 new coef");
    drain();

    // R7: simultaneous write and step, write first
    fork
      write_col(1, 4, 20000, 20000, 20000);
      step(1, 0, 5000, "R7 same cycle");
    join
    drain();

    // R10: illegal column index ignored (would alias slot 1 column 0)
    write_col(0, 5, 131071, 131071, 131071);
    write_col(0, 7, -131072, 5, 5);
    step(1, 100, 100, "R10 m1 unchanged");
    step(0, 100, 100, "R10 m0 unchanged");
    drain();

    // R9: reset clears states, keeps coefficients
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int m = 0; m < NM; m++)
      for (int r = 0; r < NS; r++) st[m][r] = 0;
    @(negedge clk);
    chk(step_ready && cw_ready, "R9 readies after second reset", {step_ready, cw_ready}, 3);
    step(0, 300, -300, "R9 coef kept m0");
    step(3, 10, 10, "R9 coef kept m3");
    drain();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule